// File: doc/BRIEF.md
# Receive Elastic Store with Controlled Frame Slip

This block sits between a recovered receive line clock domain and the system read timing. Both timings are given as strobes in one clock. The stream is framed as 32 channel bytes per frame. The store holds two frames, 64 byte slots. A write strobe stores one channel byte at the write pointer. A read strobe returns one byte from the read pointer.

The read pointer trails the write pointer. When the two drift too close together or too far apart, the read pointer is moved by exactly one frame at a frame boundary. A whole frame is then either replayed or skipped, and channel alignment is never broken. Each correction sets a sticky slip flag, records its direction, and can raise a maskable interrupt.

A short mode reduces the store to one frame. In short mode no frame correction takes place. Only byte-level underflow and overflow are reported, through the same flag and direction outputs.

Top module: `es_elastic_store`

## Requirements
- R1: After synchronous reset, rd_data, slip_flag, slip_dir and slip_irq are all 0. The read pointer starts 34 slots behind the write pointer in normal mode.
- R2: With no slip, bytes come out of rd_data one clock after their read strobe, in the order they were written, through a 64-slot store.
- R3: In normal mode, fill is the write pointer minus the read pointer, modulo 64. If a read strobe falls on channel 0 of a frame while the fill is 2 or less, that read and the reads after it come from one frame earlier, so a frame is repeated. The fill then grows by 32, and slip_dir becomes 1.
- R4: In normal mode, if a read strobe falls on channel 0 of a frame while the fill is 60 or more, the read skips forward one frame, so a frame is dropped. The fill then shrinks by 32, and slip_dir becomes 0.
- R5: A normal-mode slip happens only on a read of frame channel 0. A fill that is out of range on any other read changes nothing until the next frame boundary.
- R6: slip_flag is set by any slip, underflow or overflow event and stays set. It is cleared by a one-cycle high on slip_clr. If an event and a clear arrive in the same cycle, the flag stays set.
- R7: slip_dir keeps the direction of the most recent event (1 = data repeated, 0 = data lost) until the next event.
- R8: slip_irq is high exactly when slip_flag and slip_mask are both high.
- R9: With short_mode = 1, the store is 32 slots and frame slips never occur.
- R10: In short mode, a read strobe with fill 0 is an underflow. rd_data repeats the previous byte, the read pointer holds, and slip_dir becomes 1.
- R11: In short mode, a write strobe without a read strobe at fill 32 is an overflow. The oldest unread byte is discarded, the fill stays 32, and slip_dir becomes 0.
- R12: In the first cycle in which short_mode differs from the mode in use, both strobes are ignored. The read pointer is re-placed 34 slots (normal) or 16 slots (short) behind the write pointer, with no status event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one channel byte |
| wr_data | input | 8 | Channel byte to store |
| rd_en | input | 1 | Read strobe, one channel byte |
| rd_data | output | 8 | Byte read, valid the cycle after rd_en |
| short_mode | input | 1 | 1 selects the one-frame store without slips |
| slip_clr | input | 1 | Write-one-to-clear for slip_flag |
| slip_mask | input | 1 | Interrupt enable |
| slip_flag | output | 1 | Sticky event flag |
| slip_dir | output | 1 | Direction of last event, 1 repeated, 0 lost |
| slip_irq | output | 1 | Masked interrupt |

## Verification
A slip event and a software clear can land in the same clock edge. This is provoked by holding slip_clr high through a whole read-faster run. Frame repeats then fire on boundaries the bench predicts from its own pointer arithmetic. The flag must read 1 only in the cycle after each repeat and 0 otherwise, with slip_dir and slip_irq following. Drift rates, short-mode drains and floods, and a long pseudo-random strobe mix are compared slot by slot against a bench model of the pointers.

// File: rtl/es_pkg.sv
package es_pkg;

    localparam int ES_BYTE_W     = 8;
    localparam int ES_FRAME_CH   = 32;
    localparam int ES_NEAR_LIM   = 2;
    localparam int ES_FAR_LIM    = 60;
    localparam int ES_INIT_NORM  = 34;
    localparam int ES_INIT_SHORT = 16;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_REPEAT,
        EV_DROP,
        EV_UNDER,
        EV_OVER
    } es_evt_e;

    typedef struct packed {
        logic hit;
        logic dir;
    } es_evt_t;

    function automatic es_evt_t evt_decode(es_evt_e k);
        es_evt_t e;
        e.hit = (k != EV_NONE);
        e.dir = (k == EV_REPEAT) || (k == EV_UNDER);
        return e;
    endfunction

endpackage

// File: rtl/es_store.sv
module es_store #(
    parameter int DEPTH  = 64,
    parameter int BYTE_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read-first: a same-cycle write to the read slot is not seen.
    always_ff @(posedge clk) begin
        if (rst)     rdata <= '0;
        else if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/es_ptr_ctrl.sv
module es_ptr_ctrl
    import es_pkg::*;
#(
    parameter int FRAME_CH   = ES_FRAME_CH,
    parameter int NEAR_LIM   = ES_NEAR_LIM,
    parameter int FAR_LIM    = ES_FAR_LIM,
    parameter int INIT_NORM  = ES_INIT_NORM,
    parameter int INIT_SHORT = ES_INIT_SHORT,
    localparam int DEPTH     = 2 * FRAME_CH,
    localparam int PW        = $clog2(DEPTH),
    localparam int FW        = $clog2(FRAME_CH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          short_mode,
    output logic          wr_do,
    output logic [PW-1:0] wr_addr,
    output logic          rd_do,
    output logic [PW-1:0] rd_addr,
    output es_evt_e       evt_kind
);
    logic [PW-1:0] wp_q, rp_q, wp_d, rp_d;
    logic          mode_q;
    logic [PW-1:0] fill;
    logic [PW-1:0] rp_eff;
    logic          realign, at_boundary;
    logic          near_hit, far_hit, slip_now;
    logic          under, over;

    assign realign     = (short_mode != mode_q);
    assign fill        = wp_q - rp_q;
    assign at_boundary = (rp_q[FW-1:0] == '0);

    // Frame-slip decision: normal mode only, on channel 0 reads.
    assign near_hit = !mode_q && rd_en && at_boundary && (fill <= PW'(NEAR_LIM));
    assign far_hit  = !mode_q && rd_en && at_boundary && (fill >= PW'(FAR_LIM));
    assign slip_now = !realign && (near_hit || far_hit);

    // Byte-level faults: short mode only.
    assign under = !realign && mode_q && rd_en && (fill == '0);
    assign over  = !realign && mode_q && wr_en && !rd_en && (fill == PW'(FRAME_CH));

    // One frame either way is the same slot in a two-frame ring.
    assign rp_eff = slip_now ? rp_q + PW'(FRAME_CH) : rp_q;

    always_comb begin
        evt_kind = EV_NONE;
        if (slip_now)   evt_kind = near_hit ? EV_REPEAT : EV_DROP;
        else if (under) evt_kind = EV_UNDER;
        else if (over)  evt_kind = EV_OVER;
    end

    assign wr_do = wr_en && !realign;
    assign rd_do = rd_en && !realign && !under;

    generate
        if (FW < PW) begin : g_addr
            assign wr_addr = mode_q ? {{(PW-FW){1'b0}}, wp_q[FW-1:0]} : wp_q;
            assign rd_addr = mode_q ? {{(PW-FW){1'b0}}, rp_eff[FW-1:0]} : rp_eff;
        end else begin : g_addr_flat
            assign wr_addr = wp_q;
            assign rd_addr = rp_eff;
        end
    endgenerate

    always_comb begin
        wp_d = wr_do ? wp_q + PW'(1) : wp_q;
        rp_d = rp_q;
        if (realign)             rp_d = wp_q - (short_mode ? PW'(INIT_SHORT) : PW'(INIT_NORM));
        else if (rd_do)          rp_d = rp_eff + PW'(1);
        else if (over)           rp_d = rp_q + PW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp_q   <= '0;
            rp_q   <= '0 - PW'(INIT_NORM);
            mode_q <= 1'b0;
        end else begin
            wp_q   <= wp_d;
            rp_q   <= rp_d;
            mode_q <= short_mode;
        end
    end

    // R3: a repeat slip lifts the fill by one frame (less the read, plus any write)
    assert_repeat_fill_R3: assert property (@(posedge clk) disable iff (rst)
        (evt_kind == EV_REPEAT) |=>
        (fill == PW'($past(fill) + PW'(FRAME_CH) + PW'($past(wr_do)) - PW'(1))));

    // R4: a drop slip lowers the fill by one frame
    assert_drop_fill_R4: assert property (@(posedge clk) disable iff (rst)
        (evt_kind == EV_DROP) |=>
        (fill == PW'($past(fill) - PW'(FRAME_CH) + PW'($past(wr_do)) - PW'(1))));

    // R9: in short mode the fill never exceeds one frame
    assert_short_bound_R9: assert property (@(posedge clk) disable iff (rst)
        (mode_q && !realign) |-> (fill <= PW'(FRAME_CH)));

    // R5: after a slip the read continues at channel 1 of a frame
    assert_slip_on_boundary_R5: assert property (@(posedge clk) disable iff (rst)
        ((evt_kind == EV_REPEAT) || (evt_kind == EV_DROP)) |=> (rp_q[FW-1:0] == FW'(1)));
endmodule

// File: rtl/es_status.sv
module es_status
    import es_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  es_evt_e evt_kind,
    input  logic    clr,
    input  logic    mask,
    output logic    flag,
    output logic    dir,
    output logic    irq
);
    es_evt_t evt;

    assign evt = evt_decode(evt_kind);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            dir  <= 1'b0;
        end else begin
            flag <= evt.hit | (flag & ~clr);
            if (evt.hit) dir <= evt.dir;
        end
    end

    assign irq = flag & mask;

    // R6: an event wins over a clear in the same cycle
    assert_set_wins_R6: assert property (@(posedge clk) disable iff (rst)
        evt.hit |=> flag);

    // R6: a clear with no event empties the flag
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr && !evt.hit) |=> !flag);

    // R7: direction is held between events
    assert_dir_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !evt.hit |=> $stable(dir));
endmodule

// File: rtl/es_elastic_store.sv
module es_elastic_store
    import es_pkg::*;
#(
    parameter int BYTE_W     = ES_BYTE_W,
    parameter int FRAME_CH   = ES_FRAME_CH,
    parameter int NEAR_LIM   = ES_NEAR_LIM,
    parameter int FAR_LIM    = ES_FAR_LIM,
    parameter int INIT_NORM  = ES_INIT_NORM,
    parameter int INIT_SHORT = ES_INIT_SHORT,
    localparam int DEPTH     = 2 * FRAME_CH,
    localparam int PW        = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              short_mode,
    input  logic              slip_clr,
    input  logic              slip_mask,
    output logic              slip_flag,
    output logic              slip_dir,
    output logic              slip_irq
);
    logic          wr_do, rd_do;
    logic [PW-1:0] wr_addr, rd_addr;
    es_evt_e       evt_kind;

    es_ptr_ctrl #(
        .FRAME_CH  (FRAME_CH),
        .NEAR_LIM  (NEAR_LIM),
        .FAR_LIM   (FAR_LIM),
        .INIT_NORM (INIT_NORM),
        .INIT_SHORT(INIT_SHORT)
    ) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .short_mode(short_mode),
        .wr_do     (wr_do),
        .wr_addr   (wr_addr),
        .rd_do     (rd_do),
        .rd_addr   (rd_addr),
        .evt_kind  (evt_kind)
    );

    es_store #(
        .DEPTH (DEPTH),
        .BYTE_W(BYTE_W)
    ) u_store (
        .clk  (clk),
        .rst  (rst),
        .we   (wr_do),
        .waddr(wr_addr),
        .wdata(wr_data),
        .re   (rd_do),
        .raddr(rd_addr),
        .rdata(rd_data)
    );

    es_status u_status (
        .clk     (clk),
        .rst     (rst),
        .evt_kind(evt_kind),
        .clr     (slip_clr),
        .mask    (slip_mask),
        .flag    (slip_flag),
        .dir     (slip_dir),
        .irq     (slip_irq)
    );

    // R8: interrupt only with flag and enable both present
    assert_irq_gate_R8: assert property (@(posedge clk) disable iff (rst)
        slip_irq |-> (slip_flag && slip_mask));
endmodule

// File: tb/es_elastic_store_tb.sv
module es_elastic_store_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en, rd_en, short_mode, slip_clr, slip_mask;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic       slip_flag, slip_dir, slip_irq;

    always #2.5 clk = ~clk;

    es_elastic_store u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .short_mode(short_mode), .slip_clr(slip_clr),
        .slip_mask(slip_mask), .slip_flag(slip_flag), .slip_dir(slip_dir),
        .slip_irq(slip_irq)
    );

    int  n_chk = 0, n_bad = 0;
    bit  done = 0;

    // Bench model of pointers and storage
    logic [5:0] m_wp, m_rp;
    logic       m_short;
    logic [7:0] m_mem [64];
    bit         m_val [64];
    logic [7:0] m_rd;
    bit         m_rdk;
    bit         m_flag, m_dir;
    logic [7:0] dcnt;
    logic [15:0] lfsr = 16'hACE1;

    task automatic chk(input bit ok, input string tag, input string what, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic step(input bit wr, input bit rd, input bit sh, input bit clr, input bit msk, input string tag);
        logic [5:0] occ, a;
        bit ev, evd, unf, ovf, slip;
        @(negedge clk);
        wr_en = wr; rd_en = rd; short_mode = sh; slip_clr = clr; slip_mask = msk; wr_data = dcnt;
        @(posedge clk); #1;
        ev = 0; evd = 0;
        if (sh != m_short) begin
            m_short = sh;
            m_rp = m_wp - (sh ? 6'd16 : 6'd34);
        end else begin
            occ = m_wp - m_rp;
            if (sh) begin
                unf = rd && occ == 6'd0;
                ovf = wr && !rd && occ == 6'd32;
                a = {1'b0, m_rp[4:0]};
                if (rd && !unf) begin m_rd = m_mem[a]; m_rdk = m_val[a]; end
                if (wr) begin m_mem[{1'b0, m_wp[4:0]}] = dcnt; m_val[{1'b0, m_wp[4:0]}] = 1; m_wp = m_wp + 6'd1; end
                if ((rd && !unf) || ovf) m_rp = m_rp + 6'd1;
                ev = unf || ovf; evd = unf;
            end else begin
                slip = rd && m_rp[4:0] == 5'd0 && (occ <= 6'd2 || occ >= 6'd60);
                evd = occ <= 6'd2;
                a = slip ? m_rp + 6'd32 : m_rp;
                if (rd) begin m_rd = m_mem[a]; m_rdk = m_val[a]; m_rp = a + 6'd1; end
                if (wr) begin m_mem[m_wp] = dcnt; m_val[m_wp] = 1; m_wp = m_wp + 6'd1; end
                ev = slip;
            end
        end
        m_flag = ev || (m_flag && !clr);
        if (ev) m_dir = evd;
        dcnt = dcnt + 8'd1;
        chk(slip_flag == m_flag, tag, "slip_flag R6", int'(slip_flag), int'(m_flag));
        chk(slip_dir == m_dir, tag, "slip_dir R7", int'(slip_dir), int'(m_dir));
        chk(slip_irq == (m_flag && msk), tag, "slip_irq R8", int'(slip_irq), int'(m_flag && msk));
        if (m_rdk) chk(rd_data == m_rd, tag, "rd_data R2", int'(rd_data), int'(m_rd));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; wr_en = 0; rd_en = 0; short_mode = 0; slip_clr = 0; slip_mask = 0; wr_data = 0;
        m_wp = 0; m_rp = 6'd30; m_short = 0; m_rd = 0; m_rdk = 1; m_flag = 0; m_dir = 0; dcnt = 0;
        for (int i = 0; i < 64; i++) begin m_val[i] = 0; m_mem[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1: reset state
        chk(rd_data == 8'd0, "R1", "rd_data", int'(rd_data), 0);
        chk(slip_flag == 1'b0, "R1", "slip_flag", int'(slip_flag), 0);
        chk(slip_dir == 1'b0, "R1", "slip_dir", int'(slip_dir), 0);
        chk(slip_irq == 1'b0, "R1", "slip_irq", int'(slip_irq), 0);

        // R2 and R1 separation: balanced traffic, no slip
        for (int i = 0; i < 200; i++) step(1, 1, 0, 0, 1, "R2");

        // R4: write side faster, drift sweep over several periods
        for (int k = 12; k <= 32; k += 4)
            for (int i = 0; i < 360; i++) step(1, (i % k) != 0, 0, (i == 0), 1, "R4");

        // R6: single clear pulse with balanced traffic
        step(1, 1, 0, 1, 1, "R6");
        for (int i = 0; i < 40; i++) step(1, 1, 0, 0, 0, "R6");

        // R3 with clear held high: event and clear collide
        for (int k = 12; k <= 32; k += 4)
            for (int i = 0; i < 360; i++) step((i % k) != 0, 1, 0, 1, i[3], "R3");

        // R5: reads only, fill runs out mid-frame
        for (int i = 0; i < 80; i++) step(0, 1, 0, 0, 1, "R5");
        for (int i = 0; i < 40; i++) step(1, 0, 0, 0, 1, "R5");

        // R12 then R9: into short mode, balanced
        step(1, 1, 1, 1, 1, "R12");
        for (int i = 0; i < 100; i++) step(1, 1, 1, 0, 1, "R9");
        // R10: drain until underflow
        for (int i = 0; i < 30; i++) step(0, 1, 1, (i == 0), 1, "R10");
        step(1, 0, 1, 1, 1, "R10");
        // R11: flood until overflow
        for (int i = 0; i < 45; i++) step(1, 0, 1, 0, 1, "R11");
        for (int i = 0; i < 40; i++) step(0, 1, 1, 0, 1, "R11");

        // R12 back to normal, then mixed strobes in both modes
        step(1, 1, 0, 1, 1, "R12");
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[1], lfsr[2] | lfsr[3], (i >= 1500) && (i < 2300),
                 lfsr[9:5] == 5'd0, lfsr[11], "R7");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule